// File: doc/BRIEF.md
# Standby Refresh Command Discriminator

This block sits inside a pseudo-static memory device. It watches the chip enable and the shared output-enable/refresh pin, both active low, on a fast internal sampling clock. While chip enable is low the shared pin acts as an output enable and is ignored here. While chip enable is high the block measures the width of each low pulse on the shared pin. Pulses that are too short are flagged as illegal. Medium pulses start one automatic refresh. A pulse held past the self-refresh threshold enters self refresh, where an internal timer paces further refreshes until the pin rises.

Every refresh, of either kind, takes its row from an internal wrapping row counter. The block drives a one-cycle refresh strobe together with that row. After an access, refresh is disarmed until the pin has been seen high in standby. After self refresh ends, a recovery window must pass with both inputs high. A low on either input inside that window is reported as a violation and starts no refresh.

All thresholds are parameters counted in sampling-clock cycles. With the defaults the clock runs at 125 MHz. The illegal limit is 80 ns, the self-refresh threshold is 8 us and the recovery window is 600 ns. The self-refresh period is 15.2 us, which meets the budget of 2048 rows in 32 ms.

Top module: `refcmd_discriminator`

## Requirements
- R1: While en_n is low, low levels on oe_ref_n produce no refresh strobe and no error.
- R2: After en_n rises with oe_ref_n still low, no refresh starts until oe_ref_n has been sampled high with en_n high. Only the next falling edge starts a measurement.
- R3: A standby low pulse of fewer than MIN_LOW_CYC sampled cycles pulses short_err for one cycle and produces no refresh strobe.
- R4: A standby low pulse of MIN_LOW_CYC to SELF_LOW_CYC sampled cycles, inclusive, gives exactly one ref_stb. The strobe is high in the cycle after the first high sample.
- R5: Once the pin has been sampled low for SELF_LOW_CYC+1 cycles, self_active rises and one refresh strobe is issued in that same cycle.
- R6: In self refresh, a strobe is issued every SELF_PERIOD_CYC samples, counting the sample in which the pin rises. A pulse of N low samples (N > SELF_LOW_CYC) therefore yields 1 + (N - SELF_LOW_CYC) / SELF_PERIOD_CYC strobes, using integer division. self_active falls when the pin is sampled high.
- R7: ref_row is the value of an 11-bit row counter. The counter is 0 after reset, advances by one after each strobe, and wraps from 2047 to 0.
- R8: After self refresh, RECOV_CYC samples with both inputs high are needed before refresh rearms. A low on either input in that window pulses recov_err once, starts no refresh and restarts the window.
- R9: During and right after reset, ref_stb, short_err, recov_err, self_active and ref_row are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Chip enable, active low |
| oe_ref_n | input | 1 | Shared output-enable / refresh command, active low |
| ref_stb | output | 1 | One-cycle refresh strobe |
| ref_row | output | 11 | Row refreshed with the strobe |
| self_active | output | 1 | Self refresh in progress |
| short_err | output | 1 | One-cycle flag for an illegal short pulse |
| recov_err | output | 1 | One-cycle flag for a recovery-window violation |

## Verification
The pin rising out of self refresh can coincide with the self-refresh timer expiring. In that cycle the block both leaves self refresh and owes a paced refresh. The bench provokes this with a pulse of exactly SELF_LOW_CYC + SELF_PERIOD_CYC low samples. It expects a strobe in the cycle after the rising sample, with self_active already low, and two strobes in total. Random pulse widths that land on this alignment are judged by the same strobe-count formula, and the row order is checked on every strobe.

// File: rtl/refcmd_pkg.sv
package refcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_SELF  = 2'd2,
    ST_RECOV = 2'd3
  } refcmd_state_e;
endpackage

// File: rtl/refcmd_row_ctr.sv
module refcmd_row_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (adv) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row_o = row_q;

  // R7: wrap from the top row back to zero
  p_row_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (row_q == {ROW_W{1'b1}})) |=> (row_q == '0));
endmodule

// File: rtl/refcmd_self_timer.sv
module refcmd_self_timer #(
  parameter int PERIOD_CYC = 1900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(PERIOD_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  // R6: paced ticks never fire back to back
  p_tick_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && PERIOD_CYC > 1) |=> !tick);
  // R6: timer restarts from zero whenever self refresh is not running
  p_timer_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/refcmd_pulse_fsm.sv
module refcmd_pulse_fsm
  import refcmd_pkg::*;
#(
  parameter int MIN_LOW_CYC  = 10,
  parameter int SELF_LOW_CYC = 1000,
  parameter int RECOV_CYC    = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          oe_ref_n,
  input  logic          tick,
  output refcmd_state_e state_o,
  output logic          req_o,
  output logic          short_o,
  output logic          recov_o
);
  localparam int MAXC = (SELF_LOW_CYC > RECOV_CYC) ? SELF_LOW_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 2);
  localparam logic [CW-1:0] C_MIN   = CW'(MIN_LOW_CYC);
  localparam logic [CW-1:0] C_SELF  = CW'(SELF_LOW_CYC);
  localparam logic [CW-1:0] C_RECOV = CW'(RECOV_CYC);

  refcmd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    req_o   = 1'b0;
    short_o = 1'b0;
    recov_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!en_n)         armed_d = 1'b0;
        else if (oe_ref_n) armed_d = 1'b1;
        else if (armed_q) begin
          state_d = ST_LOW;
          cnt_d   = CW'(1);
          armed_d = 1'b0;
        end
      end
      ST_LOW: begin
        if (!en_n) begin
          state_d = ST_IDLE;
          armed_d = 1'b0;
        end else if (oe_ref_n) begin
          state_d = ST_IDLE;
          armed_d = 1'b1;
          if (cnt_q < C_MIN) short_o = 1'b1;
          else               req_o   = 1'b1;
        end else if (cnt_q == C_SELF) begin
          state_d = ST_SELF;
          req_o   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SELF: begin
        req_o = tick;
        if (oe_ref_n) begin
          state_d = ST_RECOV;
          cnt_d   = CW'(1);
        end
      end
      ST_RECOV: begin
        if (en_n && oe_ref_n) begin
          if (cnt_q >= C_RECOV) begin
            state_d = ST_IDLE;
            armed_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q != '0) recov_o = 1'b1;
          cnt_d = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign state_o = state_q;

  // R8: a recovery window never hands over directly to a new measurement
  p_recov_no_measure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV) |=> (state_q != ST_LOW));
  // R2: a measurement only starts from an armed idle state
  p_arm_before_measure_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !armed_q) |=> (state_q != ST_LOW));
endmodule

// File: rtl/refcmd_discriminator.sv
module refcmd_discriminator
  import refcmd_pkg::*;
#(
  parameter int ROW_W           = 11,
  parameter int MIN_LOW_CYC     = 10,
  parameter int SELF_LOW_CYC    = 1000,
  parameter int RECOV_CYC       = 75,
  parameter int SELF_PERIOD_CYC = 1900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             oe_ref_n,
  output logic             ref_stb,
  output logic [ROW_W-1:0] ref_row,
  output logic             self_active,
  output logic             short_err,
  output logic             recov_err
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  refcmd_state_e    st;
  logic             req_c, short_c, recov_c, tick_c;
  logic [ROW_W-1:0] row_c;

  refcmd_pulse_fsm #(
    .MIN_LOW_CYC (MIN_LOW_CYC),
    .SELF_LOW_CYC(SELF_LOW_CYC),
    .RECOV_CYC   (RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .en_n(en_n), .oe_ref_n(oe_ref_n),
    .tick(tick_c), .state_o(st), .req_o(req_c),
    .short_o(short_c), .recov_o(recov_c)
  );

  refcmd_self_timer #(.PERIOD_CYC(SELF_PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run(st == ST_SELF), .tick(tick_c)
  );

  refcmd_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n_s), .adv(req_c), .row_o(row_c)
  );

  logic             stb_q, short_q, recov_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stb_q   <= 1'b0;
      short_q <= 1'b0;
      recov_q <= 1'b0;
      row_q   <= '0;
    end else begin
      stb_q   <= req_c;
      short_q <= short_c;
      recov_q <= recov_c;
      if (req_c) row_q <= row_c;
    end
  end

  assign ref_stb     = stb_q;
  assign ref_row     = row_q;
  assign short_err   = short_q;
  assign recov_err   = recov_q;
  assign self_active = (st == ST_SELF);

  // R1: an access cycle in idle never produces a strobe next
  p_access_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_IDLE && !en_n) |=> !ref_stb);
  // R3: an illegal pulse never comes with a refresh
  p_short_no_ref_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    short_err |-> !ref_stb);
  // R5: entering self refresh is accompanied by a refresh
  p_self_entry_ref_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(self_active) |-> ref_stb);
  // R8: a recovery violation never comes with a refresh
  p_recov_no_ref_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    recov_err |-> !ref_stb);
  // R7: consecutive strobes carry consecutive rows
  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ref_stb && !self_active && $past(ref_stb)) |-> (ref_row == $past(ref_row) + 1'b1));
endmodule

// File: tb/refcmd_discriminator_test.sv
module refcmd_discriminator_test;
  localparam int MINC = 10;
  localparam int SELFC = 1000;
  localparam int RECC = 75;
  localparam int PER = 1900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_n = 1'b1;
  logic        oe_ref_n = 1'b1;
  logic        ref_stb, self_active, short_err, recov_err;
  logic [10:0] ref_row;

  always #4 clk = ~clk;

  refcmd_discriminator uut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .oe_ref_n(oe_ref_n),
    .ref_stb(ref_stb), .ref_row(ref_row), .self_active(self_active),
    .short_err(short_err), .recov_err(recov_err)
  );

  int checks = 0;
  int errors = 0;
  int nref = 0, nshort = 0, nrecov = 0, row_bad = 0;
  bit seen_wrap = 0;
  bit mon_on = 0;
  logic [10:0] mon_row = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_refs(input int n);
    if (n < MINC) return 0;
    if (n <= SELFC) return 1;
    return 1 + (n - SELFC) / PER;
  endfunction

  function automatic int exp_short(input int n);
    return (n < MINC) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (ref_stb) begin
        nref++;
        if (ref_row != mon_row) row_bad++;
        if (ref_row == 11'd0 && nref > 2000) seen_wrap = 1;
        mon_row = mon_row + 11'd1;
      end
      if (short_err) nshort++;
      if (recov_err) nrecov++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en_n = 1'b1;
      oe_ref_n = 1'b1;
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    oe_ref_n = 1'b0;
    repeat (n) @(negedge clk);
    oe_ref_n = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0, s0, r0, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ref_stb == 0 && short_err == 0 && recov_err == 0 && self_active == 0 && ref_row == 0,
          "R9 outputs in reset", {ref_stb, short_err, recov_err, self_active}, 0);
    rst_n = 1'b1;
    idle(6);
    check(ref_stb == 0 && self_active == 0 && ref_row == 0, "R9 outputs after reset",
          {ref_stb, self_active}, 0);
    mon_on = 1;

    // R4 exact timing and first row
    b0 = nref;
    pulse(20);
    @(negedge clk);
    check(ref_stb == 1, "R4 strobe after rising sample", ref_stb, 1);
    check(ref_row == 0, "R7 first row is zero", ref_row, 0);
    @(negedge clk);
    check(ref_stb == 0, "R4 strobe lasts one cycle", ref_stb, 0);
    idle(3);
    check(nref - b0 == 1, "R4 one refresh", nref - b0, 1);

    // R3 short pulse
    b0 = nref; s0 = nshort;
    pulse(MINC - 1);
    @(negedge clk);
    check(short_err == 1, "R3 short flag", short_err, 1);
    idle(3);
    check(nref == b0, "R3 no refresh on short", nref - b0, 0);
    check(nshort - s0 == 1, "R3 one short flag", nshort - s0, 1);

    // R5 / R6 self refresh
    b0 = nref;
    n = SELFC + 2 * PER + 3;
    @(negedge clk);
    oe_ref_n = 1'b0;
    repeat (SELFC + 5) @(negedge clk);
    check(self_active == 1, "R5 self active", self_active, 1);
    repeat (n - SELFC - 5) @(negedge clk);
    oe_ref_n = 1'b1;
    @(negedge clk);
    check(self_active == 0, "R6 self ends on rise", self_active, 0);
    idle(RECC + 8);
    check(nref - b0 == exp_refs(n), "R6 self refresh count", nref - b0, exp_refs(n));

    // R6 exit coinciding with timer expiry
    b0 = nref;
    pulse(SELFC + PER);
    @(negedge clk);
    check(ref_stb == 1 && self_active == 0, "R6 strobe on exit cycle", {ref_stb, self_active}, 2);
    idle(RECC + 8);
    check(nref - b0 == 2, "R6 exit-aligned count", nref - b0, 2);

    // R8 recovery violation
    b0 = nref; r0 = nrecov;
    pulse(SELFC + 10);
    idle(20);
    pulse(5);
    idle(3);
    check(nrecov - r0 == 1, "R8 violation flagged", nrecov - r0, 1);
    check(nref - b0 == 1, "R8 no refresh from violation", nref - b0, 1);
    idle(RECC + 8);
    pulse(20);
    idle(3);
    check(nref - b0 == 2, "R8 rearmed after window", nref - b0, 2);

    // R2 arming after access with pin low
    b0 = nref; s0 = nshort;
    @(negedge clk);
    en_n = 1'b0; oe_ref_n = 1'b0;
    repeat (3) @(negedge clk);
    en_n = 1'b1;
    repeat (30) @(negedge clk);
    oe_ref_n = 1'b1;
    idle(3);
    check(nref == b0 && nshort == s0, "R2 disarmed after access", nref - b0, 0);
    pulse(20);
    idle(3);
    check(nref - b0 == 1, "R2 next edge refreshes", nref - b0, 1);

    // R1 output-enable use during access
    b0 = nref; s0 = nshort;
    @(negedge clk);
    en_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); oe_ref_n = 1'b0;
      repeat (3) @(negedge clk);
      oe_ref_n = 1'b1;
    end
    @(negedge clk); en_n = 1'b1;
    idle(4);
    check(nref == b0 && nshort == s0, "R1 no refresh during access", nref - b0, 0);

    // random widths with boundary picks
    for (int it = 0; it < 30; it++) begin
      int sel;
      sel = $urandom % 4;
      case (sel)
        0: n = 1 + ($urandom % (MINC - 1));
        1: n = MINC + ($urandom % (SELFC - MINC + 1));
        2: n = SELFC + 1 + ($urandom % (2 * PER));
        default: begin
          case ($urandom % 5)
            0: n = MINC - 1;
            1: n = MINC;
            2: n = SELFC;
            3: n = SELFC + 1;
            default: n = SELFC + PER;
          endcase
        end
      endcase
      b0 = nref; s0 = nshort;
      pulse(n);
      idle(n > SELFC ? RECC + 8 : 3);
      check(nref - b0 == exp_refs(n), "R4 R5 R6 random refresh count", nref - b0, exp_refs(n));
      check(nshort - s0 == exp_short(n), "R3 random short flag", nshort - s0, exp_short(n));
    end

    // R7 wrap
    for (int k = 0; k < 2100; k++) begin
      pulse(MINC);
      idle(1);
    end
    idle(3);
    check(seen_wrap, "R7 row wrapped to zero", seen_wrap, 1);
    check(row_bad == 0, "R7 rows in order", row_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule